// File: doc/BRIEF.md
# Performance Counter Unit with Global Gating

This block holds a bank of event counters for hardware performance monitoring. Each counter has a small control word. That word selects one of eight single-cycle event pulse inputs and carries a local enable. A single shared gate word sits above all the counters. A counter advances on an event pulse only when both its local enable and its gate bit are set. Software can therefore start or freeze the whole bank with one register write. Every gated counter then changes state on the same clock edge, so counters watching the same event stay in lockstep.

When a counter wraps past its largest value, it raises a flag in a shared overflow word. The interrupt output stays high while any flag is set. Software clears flags through a separate write-one-to-clear address. If a wrap and a clear land in the same cycle, the wrap takes priority. A read-only capability word reports how many counters are built.

All state is reached through a flat register port. A write takes effect on the clock edge where the write strobe is sampled. Reads are combinational from the address.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, the gate word, the overflow word, every counter value and every control word read as zero, and `irq` is low.
- R2: Counter i sits at address 0x100+i and its control word at address 0x000+i. In the control word, bit 22 is the local enable and bits [2:0] select the event input. Counter i increments by one on an edge where its selected event input is high, its local enable is set and gate bit i is set. If either enable is clear, the counter holds.
- R3: The gate word is at 0x301, and bit i gates counter i. One write to it starts or stops all counters on the same edge. Counters with identical set-up that are gated together end with equal values. With the gate word at zero, no counter moves except through a direct write.
- R4: When counter i is all ones and increments, it becomes zero and overflow bit i (in the word at 0x300) is set on that same edge.
- R5: Writing a 1 to bit i at 0x302 clears overflow bit i, and writing 0 leaves it alone. Address 0x302 reads as zero. Writes to 0x300 have no effect, so overflow bits never clear by any other path.
- R6: If an overflow of counter i and a clear of bit i happen on the same edge, bit i ends set.
- R7: `irq` is high exactly while at least one overflow bit is set.
- R8: Address 0x304 reads the counter count N (1 to 15) in bits [3:0] and zero above. Writes to it are ignored.
- R9: Gate and clear bits at or above N are ignored on write and read as zero. Addresses with no register read as zero.
- R10: A write to a counter address loads that value. It takes priority over an increment on the same edge and never sets an overflow bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 8 | Single-cycle event pulses, one per event code |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | CNT_W (48) | Write data |
| reg_rdata | output | CNT_W (48) | Combinational read data for `reg_addr` |
| irq | output | 1 | High while any overflow bit is set |

## Verification
A write sampled on a rising edge is visible on `reg_rdata` right after that edge. An event pulse is counted on the edge that samples it, and a wrap shows up in the overflow word and on `irq` on that same edge. A new gate or control value only governs events from the following edge. The bench drives each stimulus at the falling edge and updates its reference model for the next rising edge. It compares results one nanosecond after that edge, or at the next falling edge for reads, so every comparison falls exactly on the cycle in which the result is due.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int ADDR_W  = 12;
    localparam int NUM_EVT = 8;
    localparam int SEL_W   = $clog2(NUM_EVT);
    localparam int EN_BIT  = 22;
    localparam int CAP_W   = 4;

    localparam logic [ADDR_W-1:0] CTL_BASE = 12'h000;
    localparam logic [ADDR_W-1:0] CNT_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] A_OVF    = 12'h300;
    localparam logic [ADDR_W-1:0] A_GATE   = 12'h301;
    localparam logic [ADDR_W-1:0] A_CLR    = 12'h302;
    localparam logic [ADDR_W-1:0] A_CAP    = 12'h304;
endpackage

// File: rtl/pcu_slice.sv
module pcu_slice
    import pcu_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   wdata,
    input  logic               gate_en,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               loc_en,
    output logic [SEL_W-1:0]   loc_sel,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } slice_t;

    slice_t s_d, s_q;
    logic   hit;

    always_comb begin
        s_d  = s_q;
        hit  = s_q.en & gate_en & evt_in[s_q.sel];
        wrap = 1'b0;
        if (ctl_we) begin
            s_d.en  = wdata[EN_BIT];
            s_d.sel = wdata[SEL_W-1:0];
        end
        if (cnt_we) begin
            s_d.cnt = wdata;
        end else if (hit) begin
            s_d.cnt = s_q.cnt + 1'b1;
            wrap    = &s_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign loc_en  = s_q.en;
    assign loc_sel = s_q.sel;
    assign cnt     = s_q.cnt;
endmodule

// File: rtl/pcu_global.sv
module pcu_global #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate_we,
    input  logic         clr_we,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] wrap_vec,
    output logic [N-1:0] gate,
    output logic [N-1:0] ovf,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] gate;
        logic [N-1:0] ovf;
    } glob_t;

    glob_t g_d, g_q;
    logic [N-1:0] clr_mask;

    always_comb begin
        g_d      = g_q;
        clr_mask = clr_we ? wbits : '0;
        if (gate_we) g_d.gate = wbits;
        // a wrap on this edge outranks a clear of the same bit
        g_d.ovf = (g_q.ovf & ~clr_mask) | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gate = g_q.gate;
    assign ovf  = g_q.ovf;
    assign irq  = |g_q.ovf;
endmodule

// File: rtl/pcu_rdmux.sv
module pcu_rdmux
    import pcu_pkg::*;
#(
    parameter int N     = 6,
    parameter int CNT_W = 48
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N-1:0]       en_vec,
    input  logic [N*SEL_W-1:0] sel_flat,
    input  logic [N*CNT_W-1:0] cnt_flat,
    input  logic [N-1:0]       gate,
    input  logic [N-1:0]       ovf,
    output logic [CNT_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == CTL_BASE + ADDR_W'(i)) begin
                rdata[EN_BIT]      = en_vec[i];
                rdata[SEL_W-1:0]   = sel_flat[i*SEL_W +: SEL_W];
            end
            if (addr == CNT_BASE + ADDR_W'(i)) begin
                rdata = cnt_flat[i*CNT_W +: CNT_W];
            end
        end
        case (addr)
            A_OVF:   rdata[N-1:0]     = ovf;
            A_GATE:  rdata[N-1:0]     = gate;
            A_CAP:   rdata[CAP_W-1:0] = CAP_W'(N);
            default: ;
        endcase
    end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CNT_W   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);
    logic [NUM_CTR-1:0]       en_vec;
    logic [NUM_CTR*SEL_W-1:0] sel_flat;
    logic [NUM_CTR*CNT_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       ovf_vec;
    logic [NUM_CTR-1:0]       glb_q;
    logic [NUM_CTR-1:0]       status_q;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slice
        pcu_slice #(.CNT_W(CNT_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (reg_we && (reg_addr == CTL_BASE + ADDR_W'(g))),
            .cnt_we  (reg_we && (reg_addr == CNT_BASE + ADDR_W'(g))),
            .wdata   (reg_wdata),
            .gate_en (glb_q[g]),
            .evt_in  (evt_in),
            .loc_en  (en_vec[g]),
            .loc_sel (sel_flat[g*SEL_W +: SEL_W]),
            .cnt     (cnt_flat[g*CNT_W +: CNT_W]),
            .wrap    (ovf_vec[g])
        );
    end

    pcu_global #(.N(NUM_CTR)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_we  (reg_we && (reg_addr == A_GATE)),
        .clr_we   (reg_we && (reg_addr == A_CLR)),
        .wbits    (reg_wdata[NUM_CTR-1:0]),
        .wrap_vec (ovf_vec),
        .gate     (glb_q),
        .ovf      (status_q),
        .irq      (irq)
    );

    pcu_rdmux #(.N(NUM_CTR), .CNT_W(CNT_W)) u_rdmux (
        .addr     (reg_addr),
        .en_vec   (en_vec),
        .sel_flat (sel_flat),
        .cnt_flat (cnt_flat),
        .gate     (glb_q),
        .ovf      (status_q),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter int N     = 6,
    parameter int CNT_W = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [CNT_W-1:0]   reg_rdata,
    input logic               irq,
    input logic [N-1:0]       glb_q,
    input logic [N-1:0]       status_q,
    input logic [N-1:0]       ovf_vec,
    input logic [N*CNT_W-1:0] cnt_flat
);
    initial begin
        assert_param_range_R8: assert (N >= 1 && N <= 15 && CNT_W > EN_BIT)
            else $error("parameter out of range");
    end

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_q == '0 && !reg_we) |=> $stable(cnt_flat));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_CLR) |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> ((status_q & $past(ovf_vec)) == $past(ovf_vec)));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ovf_vec != '0));

    assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CAP) |-> (reg_rdata == CNT_W'(N)));

    assert_clr_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CLR) |-> (reg_rdata == '0));

    for (genvar g = 0; g < N; g++) begin : g_step
        assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == CNT_BASE + ADDR_W'(g))
            |=> ((cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W])) ||
                 (cnt_flat[g*CNT_W +: CNT_W] == CNT_W'($past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1))));
    end
endmodule

bind perf_counter_unit pcu_checker #(.N(NUM_CTR), .CNT_W(CNT_W)) i_pcu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .glb_q     (glb_q),
    .status_q  (status_q),
    .ovf_vec   (ovf_vec),
    .cnt_flat  (cnt_flat)
);

// File: tb/test_perf_counter_unit.sv
`timescale 1ns/1ps
module test_perf_counter_unit;
    localparam int NC = 6;
    localparam int CW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    evt_in = '0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    perf_counter_unit #(.NUM_CTR(NC), .CNT_W(CW)) i_perf_counter_unit (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [CW-1:0] m_cnt [NC];
    logic [2:0]    m_sel [NC];
    logic [NC-1:0] m_en, m_glb, m_stat;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // apply one clock of stimulus and advance the reference model by that edge
    task automatic drive(input logic we, input logic [11:0] a, input logic [CW-1:0] d, input logic [7:0] e);
        logic [NC-1:0] ov;
        logic [NC-1:0] clr;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; evt_in = e;
        ov = '0;
        for (int i = 0; i < NC; i++) begin
            logic hit;
            hit = m_en[i] && m_glb[i] && e[m_sel[i]];
            if (we && a == 12'h100 + i) m_cnt[i] = d;
            else if (hit) begin
                if (m_cnt[i] == '1) ov[i] = 1'b1;
                m_cnt[i] = m_cnt[i] + 1'b1;
            end
        end
        for (int i = 0; i < NC; i++) begin
            if (we && a == i) begin
                m_en[i]  = d[22];
                m_sel[i] = d[2:0];
            end
        end
        clr = (we && a == 12'h302) ? d[NC-1:0] : '0;
        m_stat = (m_stat & ~clr) | ov;
        if (we && a == 12'h301) m_glb = d[NC-1:0];
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [CW-1:0] v, output logic irq_v);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a; evt_in = '0;
        #1;
        v = reg_rdata;
        irq_v = irq;
    endtask

    task automatic check_all(input string tag);
        logic [CW-1:0] v;
        logic i_v;
        for (int i = 0; i < NC; i++) begin
            rd(12'h100 + 12'(i), v, i_v);
            chk({tag, " R2 counter"}, v, m_cnt[i]);
            rd(12'(i), v, i_v);
            chk({tag, " R2 control"}, v, (CW'(m_en[i]) << 22) | CW'(m_sel[i]));
        end
        rd(12'h300, v, i_v);
        chk({tag, " R4 status"}, v, CW'(m_stat));
        chk({tag, " R7 irq"}, CW'(i_v), CW'(|m_stat));
        rd(12'h301, v, i_v);
        chk({tag, " R3 gate"}, v, CW'(m_glb));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired before completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] v, w;
        logic i_v;
        logic [CW-1:0] top;
        int r;
        top = '1;
        for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
        m_en = '0; m_glb = '0; m_stat = '0;
        r = $urandom(32'h5EED_0042);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h301, v, i_v); chk("R1 gate after reset", v, '0);
        rd(12'h300, v, i_v); chk("R1 status after reset", v, '0);
        chk("R1 irq after reset", CW'(i_v), '0);
        rd(12'h103, v, i_v); chk("R1 counter after reset", v, '0);
        rd(12'h002, v, i_v); chk("R1 control after reset", v, '0);

        // R8 capability, read-only
        rd(12'h304, v, i_v); chk("R8 capability", v, CW'(NC));
        drive(1'b1, 12'h304, CW'(15), 8'h00);
        rd(12'h304, v, i_v); chk("R8 capability after write", v, CW'(NC));

        // R9 upper gate bits dropped, clear address reads zero, hole reads zero
        drive(1'b1, 12'h301, '1, 8'h00);
        rd(12'h301, v, i_v); chk("R9 gate upper bits", v, CW'(6'h3F));
        rd(12'h302, v, i_v); chk("R9 clear reads zero", v, '0);
        rd(12'h0FF, v, i_v); chk("R9 unmapped reads zero", v, '0);
        drive(1'b1, 12'h301, '0, 8'h00);

        // R2 both enables needed, event select honoured
        drive(1'b1, 12'h000, (CW'(1) << 22) | CW'(2), 8'h00);
        drive(1'b0, 12'h000, '0, 8'h04);
        rd(12'h100, v, i_v); chk("R2 gate off holds", v, '0);
        drive(1'b1, 12'h301, CW'(1), 8'h00);
        drive(1'b0, 12'h000, '0, 8'h04);
        rd(12'h100, v, i_v); chk("R2 both enabled counts", v, CW'(1));
        drive(1'b0, 12'h000, '0, 8'h02);
        rd(12'h100, v, i_v); chk("R2 other event ignored", v, CW'(1));
        drive(1'b1, 12'h000, CW'(2), 8'h00);
        drive(1'b0, 12'h000, '0, 8'h04);
        rd(12'h100, v, i_v); chk("R2 local enable off holds", v, CW'(1));

        // R3 lockstep start/stop with one gate write
        drive(1'b1, 12'h001, (CW'(1) << 22) | CW'(0), 8'h00);
        drive(1'b1, 12'h002, (CW'(1) << 22) | CW'(0), 8'h00);
        drive(1'b1, 12'h301, CW'(6), 8'h01);
        for (int k = 0; k < 5; k++) drive(1'b0, 12'h000, '0, 8'h01);
        drive(1'b1, 12'h301, '0, 8'h01);
        drive(1'b0, 12'h000, '0, 8'h01);
        rd(12'h101, v, i_v); rd(12'h102, w, i_v);
        chk("R3 lockstep equal", v, w);
        chk("R3 lockstep value", v, CW'(6));

        // R4 wrap sets overflow, R7 irq follows
        drive(1'b1, 12'h102, top, 8'h00);
        drive(1'b1, 12'h301, CW'(4), 8'h00);
        drive(1'b0, 12'h000, '0, 8'h01);
        rd(12'h102, v, i_v); chk("R4 wrap to zero", v, '0);
        rd(12'h300, v, i_v); chk("R4 overflow bit", v, CW'(4));
        chk("R7 irq on overflow", CW'(i_v), CW'(1));

        // R5 write-zero no effect, status write ignored, W1C clears
        drive(1'b1, 12'h302, '0, 8'h00);
        rd(12'h300, v, i_v); chk("R5 clear with zero", v, CW'(4));
        drive(1'b1, 12'h300, '0, 8'h00);
        rd(12'h300, v, i_v); chk("R5 status write ignored", v, CW'(4));
        drive(1'b1, 12'h302, CW'(4), 8'h00);
        rd(12'h300, v, i_v); chk("R5 W1C clears", v, '0);
        chk("R7 irq drops", CW'(i_v), '0);

        // R6 wrap beats clear on the same edge
        drive(1'b1, 12'h003, (CW'(1) << 22) | CW'(7), 8'h00);
        drive(1'b1, 12'h103, top, 8'h00);
        drive(1'b1, 12'h301, CW'(8), 8'h00);
        drive(1'b1, 12'h302, CW'(8), 8'h80);
        rd(12'h300, v, i_v); chk("R6 set wins", v, CW'(8));
        drive(1'b1, 12'h302, CW'(8), 8'h00);

        // R10 load beats increment, no flag
        drive(1'b1, 12'h004, (CW'(1) << 22) | CW'(5), 8'h00);
        drive(1'b1, 12'h301, CW'(16), 8'h00);
        drive(1'b1, 12'h104, CW'(48'h1234), 8'h20);
        rd(12'h104, v, i_v); chk("R10 load priority", v, CW'(48'h1234));
        rd(12'h300, v, i_v); chk("R10 no flag on load", v, '0);

        check_all("directed");

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int op, idx;
            op  = int'($urandom % 16);
            idx = int'($urandom % NC);
            case (op)
                0, 1: drive(1'b1, 12'(idx), (CW'($urandom % 2) << 22) | CW'($urandom % 8), 8'($urandom));
                2:    drive(1'b1, 12'h301, CW'($urandom), 8'($urandom));
                3:    drive(1'b1, 12'h302, CW'($urandom), 8'($urandom));
                4:    drive(1'b1, 12'h100 + 12'(idx), top - CW'($urandom % 8), 8'($urandom));
                default: drive(1'b0, 12'h000, '0, 8'($urandom));
            endcase
            if (it % 100 == 99) check_all("random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule